// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a bank of programmable debug triggers and decides, for each instruction fetch, load or store presented to it, whether the access hits one of them. Each trigger has a control word and a compare word. The control word selects the operation types and privilege levels that the trigger watches, chooses between the address and the data value as the operand, picks one of six compare modes, and can chain the trigger to its successor. The compare word supplies the reference value, and in the masked modes it also supplies the mask. Both words are loaded through a single-cycle write port.

A request is presented with `req_valid` together with its operation type, privilege level, address, data value and the current debug-mode flag. One clock later the unit reports whether any trigger group fired, the index of the firing trigger, and the action code stored in that trigger's control word. The surrounding core decides what to do with the action. When several groups hit, the lowest-indexed group wins.

Top module: `dbg_trig_top`

## Requirements
- R1: There are four triggers. A write with `wr_sel`=0 loads `wr_data[14:0]` into the control word of trigger `wr_idx`, and `wr_sel`=1 loads the 32-bit compare word. The control fields are: bit 0 execute enable, bit 1 load enable, bit 2 store enable, bit 3 machine enable, bit 4 supervisor enable, bit 5 user enable, bit 6 operand select, bit 7 chain, bits 10:8 compare mode, bits 14:11 action. Reset clears every word, so that no trigger can hit.
- R2: When `dbg_mode` is high on a request, the result is no hit.
- R3: The operation is encoded as 0 execute, 1 load and 2 store. A trigger whose enable for the presented operation is clear does not match, and code 3 matches no trigger.
- R4: The privilege is encoded as 0 user, 1 supervisor and 3 machine. A trigger whose enable for the presented level is clear does not match, and code 2 matches no trigger.
- R5: With operand select set, the data value is compared. With it clear, the address is compared.
- R6: Mode 0 (equal) matches only when the operand equals the compare word.
- R7: Mode 1 (aligned range) counts the run of 1 bits at the bottom of the compare word, ignores that many low bits of both sides, and requires the rest to be equal. An all-ones compare word matches any operand.
- R8: Mode 2 matches when the operand is greater than or equal to the compare word, and mode 3 matches when the operand is strictly less than it. Both compares are unsigned.
- R9: Mode 4 takes the upper 16 bits of the compare word as a mask M, and matches when operand AND M equals compare AND M.
- R10: Mode 5 matches when (operand shifted right by 16) AND M equals compare AND M, with M as in R9. Modes 6 and 7 never match.
- R11: A trigger with its chain bit set only qualifies its successor. A group of triggers up to and including the first one whose chain bit is clear fires only if every member matches, and it reports the index of that last member. A trigger with its chain bit set and no successor never fires.
- R12: When several groups fire, the group with the lowest indices is reported. The reported action is the action field of the reported trigger.
- R13: The result is registered. A request accepted at one clock edge is reported on `hit_o`, `idx_o` and `action_o` after that edge. Without a valid request, the outputs are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 2 | Trigger selected by the write |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the compare word |
| wr_data | input | 32 | Write value |
| req_valid | input | 1 | Request is present this cycle |
| req_op | input | 2 | Operation type |
| req_prv | input | 2 | Privilege level |
| req_addr | input | 32 | Access or fetch address |
| req_data | input | 32 | Data value of the access |
| dbg_mode | input | 1 | Hart is in debug mode |
| hit_o | output | 1 | A trigger group fired (registered) |
| idx_o | output | 2 | Index of the firing trigger |
| action_o | output | 4 | Action field of the firing trigger |

## Verification
A corrupted control or compare word stays hidden until a request reaches the trigger that holds it. The error then appears as a wrong hit, index or action one cycle after that request. Broken chain tracking shows up only when adjacent triggers form groups: the reported index then stops at a middle member, or a group fires with a failing member. For this reason the bench rewrites the whole bank many times with random chain patterns and modes, and after each rewrite it presents operands placed close to the stored compare words.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PRV_U    = 2'd0,
        PRV_S    = 2'd1,
        PRV_RSVD = 2'd2,
        PRV_M    = 2'd3
    } prv_e;

    typedef enum logic [2:0] {
        MD_EQ    = 3'd0,
        MD_NAPOT = 3'd1,
        MD_GE    = 3'd2,
        MD_LT    = 3'd3,
        MD_MLO   = 3'd4,
        MD_MHI   = 3'd5,
        MD_X6    = 3'd6,
        MD_X7    = 3'd7
    } mode_e;

    localparam int ACT_W = 4;

    typedef struct packed {
        logic [ACT_W-1:0] action;   // 14:11
        mode_e            mode;     // 10:8
        logic             chain;    // 7
        logic             sel;      // 6
        logic             en_u;     // 5
        logic             en_s;     // 4
        logic             en_m;     // 3
        logic             en_store; // 2
        logic             en_load;  // 1
        logic             en_exec;  // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic op_ok(ctrl_t c, op_e op);
        case (op)
            OP_EXEC:  return c.en_exec;
            OP_LOAD:  return c.en_load;
            OP_STORE: return c.en_store;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic prv_ok(ctrl_t c, prv_e p);
        case (p)
            PRV_M:   return c.en_m;
            PRV_S:   return c.en_s;
            PRV_U:   return c.en_u;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
    import dbg_trig_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32,
    localparam int IDX_W = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output ctrl_t            ctrl [NTRIG],
    output logic [XLEN-1:0]  cmpv [NTRIG]
);
    for (genvar t = 0; t < NTRIG; t++) begin : g_slot
        logic hit_slot;
        assign hit_slot = wr_en && (wr_idx == IDX_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl[t] <= '0;
                cmpv[t] <= '0;
            end else if (hit_slot) begin
                if (wr_sel) cmpv[t] <= wr_data;
                else        ctrl[t] <= ctrl_t'(wr_data[CTRL_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
    import dbg_trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctrl_t           ctrl,
    input  logic [XLEN-1:0] cmpv,
    input  op_e             op,
    input  prv_e            prv,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] data,
    output logic            match
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] oper;
    logic [XLEN-1:0] keep;
    logic [XLEN-1:0] hmask;
    logic            vmatch;

    assign oper  = ctrl.sel ? data : addr;
    assign hmask = cmpv >> HALF;

    // Bit i is ignored when bits 0..i of the compare word are all ones.
    always_comb begin : g_napot
        logic run;
        run = 1'b1;
        for (int i = 0; i < XLEN; i++) begin
            run     = run & cmpv[i];
            keep[i] = ~run;
        end
    end

    always_comb begin
        case (ctrl.mode)
            MD_EQ:    vmatch = (oper == cmpv);
            MD_NAPOT: vmatch = ((oper ^ cmpv) & keep) == '0;
            MD_GE:    vmatch = (oper >= cmpv);
            MD_LT:    vmatch = (oper < cmpv);
            MD_MLO:   vmatch = ((oper ^ cmpv) & hmask) == '0;
            MD_MHI:   vmatch = (((oper >> HALF) ^ cmpv) & hmask) == '0;
            default:  vmatch = 1'b0;
        endcase
    end

    assign match = vmatch && op_ok(ctrl, op) && prv_ok(ctrl, prv);
endmodule

// File: rtl/dbg_trig_chain.sv
module dbg_trig_chain #(
    parameter int NTRIG = 4,
    localparam int IDX_W = $clog2(NTRIG)
) (
    input  logic [NTRIG-1:0] match,
    input  logic [NTRIG-1:0] chain,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin : g_walk
        logic ok;
        ok  = 1'b1;
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NTRIG; i++) begin
            if (!hit) begin
                if (!ok || !match[i]) begin
                    // group failed or skipping: next group starts after a clear chain bit
                    ok = !chain[i];
                end else if (!chain[i]) begin
                    hit = 1'b1;
                    idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/dbg_trig_top.sv
module dbg_trig_top
    import dbg_trig_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32,
    localparam int IDX_W = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_prv,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [XLEN-1:0]  req_data,
    input  logic             dbg_mode,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [ACT_W-1:0] action_o
);
    ctrl_t            ctrl [NTRIG];
    logic [XLEN-1:0]  cmpv [NTRIG];
    logic [NTRIG-1:0] match_vec;
    logic [NTRIG-1:0] chain_vec;
    logic             hit_c;
    logic [IDX_W-1:0] idx_c;
    logic             fire;

    dbg_trig_regs #(.NTRIG(NTRIG), .XLEN(XLEN)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_data(wr_data), .ctrl(ctrl), .cmpv(cmpv)
    );

    for (genvar t = 0; t < NTRIG; t++) begin : g_cmp
        dbg_trig_cmp #(.XLEN(XLEN)) u_cmp (
            .ctrl(ctrl[t]), .cmpv(cmpv[t]),
            .op(op_e'(req_op)), .prv(prv_e'(req_prv)),
            .addr(req_addr), .data(req_data), .match(match_vec[t])
        );
        assign chain_vec[t] = ctrl[t].chain;
    end

    dbg_trig_chain #(.NTRIG(NTRIG)) u_chain (
        .match(match_vec), .chain(chain_vec), .hit(hit_c), .idx(idx_c)
    );

    assign fire = req_valid && !dbg_mode && hit_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o    <= 1'b0;
            idx_o    <= '0;
            action_o <= '0;
        end else begin
            hit_o    <= fire;
            idx_o    <= fire ? idx_c : '0;
            action_o <= fire ? ctrl[idx_c].action : '0;
        end
    end
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk #(
    parameter int NTRIG = 4,
    localparam int IDX_W = $clog2(NTRIG)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [1:0]       req_prv,
    input logic             dbg_mode,
    input logic             hit_o,
    input logic [IDX_W-1:0] idx_o,
    input logic [NTRIG-1:0] chain_vec
);
    logic [NTRIG-1:0] chain_q;
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_vec;
    end

    AST_DBG_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dbg_mode) |=> !hit_o); // R2

    AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> !hit_o); // R3

    AST_BAD_PRV_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prv == 2'd2) |=> !hit_o); // R4

    AST_GROUP_END: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> !chain_q[idx_o]); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !hit_o); // R13
endmodule

bind dbg_trig_top dbg_trig_chk #(.NTRIG(NTRIG)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_prv(req_prv), .dbg_mode(dbg_mode), .hit_o(hit_o),
    .idx_o(idx_o), .chain_vec(chain_vec)
);

// File: tb/tb_dbg_trig_top.sv
`timescale 1ns/1ps
module tb_dbg_trig_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_prv = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        dbg_mode = 1'b0;
    logic        hit_o;
    logic [1:0]  idx_o;
    logic [3:0]  action_o;

    always #2.5 clk = ~clk;

    dbg_trig_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_op(req_op),
        .req_prv(req_prv), .req_addr(req_addr), .req_data(req_data),
        .dbg_mode(dbg_mode), .hit_o(hit_o), .idx_o(idx_o), .action_o(action_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [14:0] mc [N];
    logic [31:0] mv [N];
    logic [31:0] rs = 32'h2545_f491;

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic logic [31:0] mkc(bit ex, bit ld, bit st, bit m, bit s, bit u,
                                        bit sel, bit ch, int mode, int act);
        logic [31:0] c;
        c = '0;
        c[0] = ex; c[1] = ld; c[2] = st; c[3] = m; c[4] = s; c[5] = u;
        c[6] = sel; c[7] = ch; c[10:8] = mode[2:0]; c[14:11] = act[3:0];
        return c;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int i, bit sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i[1:0]; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) mv[i] = d; else mv[i] = mv[i];
        if (!sel) mc[i] = d[14:0];
    endtask

    function automatic bit tmatch(int i, int op, int prv, logic [31:0] a, logic [31:0] d);
        logic [14:0] c;
        logic [31:0] v, t, m;
        int k;
        c = mc[i]; t = mv[i];
        if (op == 3 || prv == 2) return 0;
        if (!c[op]) return 0;
        if (prv == 3 && !c[3]) return 0;
        if (prv == 1 && !c[4]) return 0;
        if (prv == 0 && !c[5]) return 0;
        v = c[6] ? d : a;
        case (int'(c[10:8]))
            0: return v == t;
            1: begin
                k = 0;
                while (k < 32 && t[k]) k++;
                m = (k == 32) ? 32'h0 : ~((32'h1 << k) - 32'h1);
                return (v & m) == (t & m);
            end
            2: return v >= t;
            3: return v < t;
            4: begin m = t >> 16; return (v & m) == (t & m); end
            5: begin m = t >> 16; return ((v >> 16) & m) == (t & m); end
            default: return 0;
        endcase
    endfunction

    task automatic model(int op, int prv, logic [31:0] a, logic [31:0] d, bit dbg,
                         output bit eh, output int ei, output logic [3:0] ea);
        int s, e;
        bit all;
        eh = 0; ei = 0; ea = '0;
        if (dbg) return;
        s = 0;
        while (s < N) begin
            e = s;
            while (e < N && mc[e][7]) e++;
            if (e == N) return;
            all = 1;
            for (int j = s; j <= e; j++) all &= tmatch(j, op, prv, a, d);
            if (all) begin eh = 1; ei = e; ea = mc[e][14:11]; return; end
            s = e + 1;
        end
    endtask

    task automatic req(int op, int prv, logic [31:0] a, logic [31:0] d, bit dbg, string tag);
        bit eh; int ei; logic [3:0] ea;
        @(negedge clk);
        req_valid = 1'b1; req_op = op[1:0]; req_prv = prv[1:0];
        req_addr = a; req_data = d; dbg_mode = dbg;
        model(op, prv, a, d, dbg, eh, ei, ea);
        @(negedge clk);
        req_valid = 1'b0; dbg_mode = 1'b0;
        chk(hit_o == eh, {tag, " hit"}, 32'(hit_o), 32'(eh));
        if (eh) begin
            chk(idx_o == ei[1:0], {tag, " idx"}, 32'(idx_o), 32'(ei));
            chk(action_o == ea, {tag, " action"}, 32'(action_o), 32'(ea));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin mc[i] = '0; mv[i] = '0; end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        chk(hit_o == 1'b0 && idx_o == '0 && action_o == '0, "R1 reset outputs",
            {hit_o, idx_o, action_o}, 32'h0);
        req(0, 3, 32'h0, 32'h0, 0, "R1 cleared bank");

        // R6 equal
        wr(0, 1, 32'h0000_1000);
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,0,5));
        req(0, 3, 32'h0000_1000, 32'h0, 0, "R6 equal hit");
        req(0, 3, 32'h0000_1004, 32'h0, 0, "R6 equal miss");
        // R13 no valid, no hit
        @(negedge clk);
        req_op = 2'd0; req_prv = 2'd3; req_addr = 32'h0000_1000; req_valid = 1'b0;
        @(negedge clk);
        chk(hit_o == 1'b0, "R13 idle no hit", 32'(hit_o), 32'h0);
        // R2 debug mode
        req(0, 3, 32'h0000_1000, 32'h0, 1, "R2 debug mode");
        // R3 op filter
        wr(0, 0, mkc(1,0,0,1,1,1,0,0,0,5));
        req(1, 3, 32'h0000_1000, 32'h0, 0, "R3 load blocked");
        req(3, 3, 32'h0000_1000, 32'h0, 0, "R3 reserved op");
        req(0, 3, 32'h0000_1000, 32'h0, 0, "R3 exec allowed");
        // R4 privilege filter
        wr(0, 0, mkc(1,1,1,1,0,0,0,0,0,5));
        req(0, 1, 32'h0000_1000, 32'h0, 0, "R4 super blocked");
        req(0, 2, 32'h0000_1000, 32'h0, 0, "R4 reserved prv");
        // R5 select data
        wr(0, 0, mkc(1,1,1,1,1,1,1,0,0,6));
        req(1, 0, 32'h0000_1000, 32'h0000_2000, 0, "R5 data compared");
        req(1, 0, 32'h0000_2000, 32'h0000_1000, 0, "R5 data hit");
        // R7 aligned range: low 4 bits ignored
        wr(0, 1, 32'h0000_300F);
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,1,7));
        req(0, 3, 32'h0000_3009, 32'h0, 0, "R7 inside");
        req(0, 3, 32'h0000_3019, 32'h0, 0, "R7 outside");
        wr(0, 1, 32'hFFFF_FFFF);
        req(0, 3, 32'h1234_5678, 32'h0, 0, "R7 all ones");
        // R8 ge / lt
        wr(0, 1, 32'h8000_0000);
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,2,3));
        req(0, 3, 32'h8000_0000, 32'h0, 0, "R8 ge equal");
        req(0, 3, 32'h7FFF_FFFF, 32'h0, 0, "R8 ge below");
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,3,3));
        req(0, 3, 32'h7FFF_FFFF, 32'h0, 0, "R8 lt below");
        req(0, 3, 32'h8000_0000, 32'h0, 0, "R8 lt equal");
        // R9 / R10 masks
        wr(0, 1, 32'h00F0_0050);
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,4,2));
        req(0, 3, 32'hABCD_EF5A, 32'h0, 0, "R9 mask low hit");
        req(0, 3, 32'hABCD_EF6A, 32'h0, 0, "R9 mask low miss");
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,5,2));
        req(0, 3, 32'h0050_0000, 32'h0, 0, "R10 mask high hit");
        req(0, 3, 32'h0040_0050, 32'h0, 0, "R10 mask high miss");
        wr(0, 0, mkc(1,1,1,1,1,1,0,0,6,2));
        req(0, 3, 32'h0050_0000, 32'h0, 0, "R10 mode 6 never");
        // R11 chain, R12 priority
        wr(0, 1, 32'h0000_0100);
        wr(0, 0, mkc(1,1,1,1,1,1,0,1,0,1));
        wr(1, 1, 32'h0000_00AA);
        wr(1, 0, mkc(1,1,1,1,1,1,1,0,0,9));
        wr(2, 1, 32'h0000_0100);
        wr(2, 0, mkc(1,1,1,1,1,1,0,0,0,12));
        req(0, 3, 32'h0000_0100, 32'h0000_00AA, 0, "R11 chain both");
        req(0, 3, 32'h0000_0100, 32'h0000_00AB, 0, "R11 chain partial R12 next group");
        wr(3, 1, 32'h0000_0100);
        wr(3, 0, mkc(1,1,1,1,1,1,0,1,0,4));
        wr(2, 0, mkc(1,1,1,1,1,1,0,1,0,12));
        req(0, 3, 32'h0000_0100, 32'h0000_00AB, 0, "R11 dangling chain");

        // sweep over random banks
        for (int it = 0; it < 300; it++) begin
            for (int i = 0; i < N; i++) begin
                logic [31:0] c, v;
                c = rnd() | rnd();
                c[7] = (rnd() % 3 == 0);
                c[10:8] = rnd() % 8;
                c[14:11] = rnd();
                v = rnd();
                if (c[10:8] == 3'd1) v = v | ((32'h1 << (rnd() % 12)) - 1);
                wr(i, 1, v);
                wr(i, 0, c);
            end
            for (int q = 0; q < 16; q++) begin
                logic [31:0] a, d;
                int pick;
                pick = rnd() % 4;
                a = (pick == 3) ? rnd() : mv[rnd() % N] ^ ((rnd() % 2) ? (32'h1 << (rnd() % 32)) : 32'h0);
                d = (pick == 2) ? rnd() : mv[rnd() % N] ^ ((rnd() % 2) ? (32'h1 << (rnd() % 32)) : 32'h0);
                req(rnd() % 4, rnd() % 4, a, d, (rnd() % 16) == 0, "R11 R12 sweep");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule